// File: doc/BRIEF.md
# Floating-Point Status and Control Register Pair

This block holds the two architectural words of a floating-point unit that software and the arithmetic pipeline share. One is a 32-bit control word. It carries eight exception-enable bits, a rounding-precision field and a rounding-mode field. The other is a 32-bit status word. It carries four result flags, a quotient byte, a per-operation exception byte and a sticky accrued-exception byte.

When an operation finishes, the datapath pulses an update strobe. With the strobe it supplies the sign and class of the result, the exceptions the operation raised, and whether the operation was a move-type transfer. Arithmetic operations refresh the four flags. Move-type transfers leave the flags alone. Every update overwrites the exception byte and ORs it into the accrued byte. If any raised exception is enabled in the control word, the block raises a one-cycle trap request on the next cycle.

Conditional operations never read stored IEEE conditions. They give a predicate select, and the block derives equal, greater, less or unordered from the four stored flags as a combinational boolean.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset, both the control word and the status word read as zero.
- R2: A control write keeps only bits 15..4: enables in bits 15..8, precision in bits 7..6 and mode in bits 5..4. Bits 31..16 and 3..0 read as zero.
- R3: Software can write the status word directly. Bits 31..28 always read zero and bits 27..0 read back as written. The flags sit in bits 27..24 (N=27, Z=26, I=25, NaN=24), the quotient in 23..16, the exception byte in 15..8 and the accrued byte in 7..0.
- R4: A non-move update sets N from the result sign. It sets Z, I and NaN from the class code: 0 finite nonzero, 1 zero, 2 infinity, 3 NaN.
- R5: A move-type update leaves bits 27..24 unchanged but still updates the exception and accrued bytes.
- R6: Every update overwrites bits 15..8 with the exception input. The exception input uses the same bit order as the enable byte of the control word.
- R7: The accrued byte ORs in each update's exceptions. It is cleared only by a status write, the state-clear input or reset.
- R8: trap_req is high for exactly the one cycle after an update whose exception input shares a set bit with the control enables.
- R9: If a register write and an update strobe fall in the same cycle, the write is applied and the update is discarded, trap included.
- R10: The state-clear input zeroes the status word on the next edge, leaves the control word intact, and overrides any write or update in that cycle.
- R11: pred_out follows pred_sel: 0 gives Z; 1 gives not (NaN or Z or N); 2 gives N and not NaN and not Z; 3 gives NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| clr_state | input | 1 | Clears the status word (null-state restore) |
| upd_valid | input | 1 | Operation-complete strobe |
| upd_is_move | input | 1 | Operation is a move-type transfer |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 2 | Result class code |
| exc_in | input | 8 | Exceptions raised by the operation |
| trap_req | output | 1 | Enabled-exception trap request |
| pred_sel | input | 2 | Predicate select |
| pred_out | output | 1 | Selected predicate value |

## Verification
The state is small and every bit of it can be read back. A corrupted flag shows on pred_out at once, in the same cycle, because the predicate is combinational on the stored flags. It also shows in the status read on the first read after the bad update. A lost or non-sticky accrued bit is visible on the first status read after any later update. A wrong enable comparison shows as a missing, extra or over-long trap pulse one edge after the strobe. A wrong write-versus-update priority leaves update data in the word that was written.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 4;
    localparam int FLAG_LSB = 24;
    localparam int QUOT_LSB = 16;
    localparam int EXC_LSB  = 8;
    localparam int ACC_LSB  = 0;
    localparam int EN_LSB   = 8;

    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_FFF0;
    localparam logic [WORD_W-1:0] STAT_MASK = 32'h0FFF_FFFF;

    typedef enum logic [1:0] {
        CLS_FINITE = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } res_class_e;

    typedef enum logic [1:0] {
        PRD_EQ = 2'd0,
        PRD_GT = 2'd1,
        PRD_LT = 2'd2,
        PRD_UN = 2'd3
    } pred_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] stat;
        logic              trap;
    } regs_t;
endpackage

// File: rtl/fpcs_classify.sv
module fpcs_classify
    import fpcs_pkg::*;
(
    input  logic              sign_i,
    input  logic [1:0]        class_i,
    output logic [FLAG_W-1:0] flags_o
);
    res_class_e cls;

    always_comb begin
        cls        = res_class_e'(class_i);
        flags_o[3] = sign_i;
        flags_o[2] = (cls == CLS_ZERO);
        flags_o[1] = (cls == CLS_INF);
        flags_o[0] = (cls == CLS_NAN);
    end
endmodule

// File: rtl/fpcs_predicate.sv
module fpcs_predicate
    import fpcs_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [1:0]        sel_i,
    output logic              hit_o
);
    logic neg, zer, nan;

    always_comb begin
        neg = flags_i[3];
        zer = flags_i[2];
        nan = flags_i[0];
        unique case (pred_e'(sel_i))
            PRD_EQ:  hit_o = zer;
            PRD_GT:  hit_o = !(nan || zer || neg);
            PRD_LT:  hit_o = neg && !nan && !zer;
            default: hit_o = nan;
        endcase
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        clr_state,
    input  logic        upd_valid,
    input  logic        upd_is_move,
    input  logic        res_sign,
    input  logic [1:0]  res_class,
    input  logic [7:0]  exc_in,
    output logic        trap_req,
    input  logic [1:0]  pred_sel,
    output logic        pred_out
);
    regs_t             r_d, r_q;
    logic [FLAG_W-1:0] flags_new;
    logic [BYTE_W-1:0] enables_q;
    logic [BYTE_W-1:0] acc_q;
    logic [FLAG_W-1:0] flags_q;

    fpcs_classify u_classify (
        .sign_i  (res_sign),
        .class_i (res_class),
        .flags_o (flags_new)
    );

    assign flags_q   = r_q.stat[FLAG_LSB +: FLAG_W];
    assign enables_q = r_q.ctrl[EN_LSB +: BYTE_W];
    assign acc_q     = r_q.stat[ACC_LSB +: BYTE_W];

    fpcs_predicate u_predicate (
        .flags_i (flags_q),
        .sel_i   (pred_sel),
        .hit_o   (pred_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.trap = 1'b0;
        if (reg_wr) begin
            if (reg_sel) r_d.stat = reg_wdata & STAT_MASK;
            else         r_d.ctrl = reg_wdata & CTRL_MASK;
        end else if (upd_valid) begin
            if (!upd_is_move) r_d.stat[FLAG_LSB +: FLAG_W] = flags_new;
            r_d.stat[EXC_LSB +: BYTE_W] = exc_in;
            r_d.stat[ACC_LSB +: BYTE_W] = acc_q | exc_in;
            r_d.trap = |(exc_in & enables_q);
        end
        if (clr_state) begin
            r_d.stat = '0;
            r_d.trap = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata = reg_sel ? r_q.stat : r_q.ctrl;
    assign trap_req  = r_q.trap;

    // Assertions
    assert_flags_hold_on_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_is_move && !reg_wr && !clr_state)
        |=> (r_q.stat[27:24] == $past(r_q.stat[27:24])));

    assert_accrued_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_sel) && !clr_state)
        |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    assert_trap_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !reg_wr && !clr_state && |(exc_in & enables_q)) |=> trap_req);

    assert_trap_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_valid && !reg_wr && !clr_state && |(exc_in & enables_q)) |=> !trap_req);

    assert_clear_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_state |=> (r_q.stat == '0));

    always_comb begin
        if (rst_n) begin
            assert_reserved_zero_R3: assert (r_q.stat[31:28] == 4'h0);
            assert_ctrl_reserved_R2: assert ((r_q.ctrl & ~CTRL_MASK) == '0);
        end
    end
endmodule

// File: tb/fp_status_ctrl_test.sv
module fp_status_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clr_state = 1'b0;
    logic        upd_valid = 1'b0;
    logic        upd_is_move = 1'b0;
    logic        res_sign = 1'b0;
    logic [1:0]  res_class = '0;
    logic [7:0]  exc_in = '0;
    logic        trap_req;
    logic [1:0]  pred_sel = '0;
    logic        pred_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fp_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clr_state(clr_state),
        .upd_valid(upd_valid), .upd_is_move(upd_is_move), .res_sign(res_sign),
        .res_class(res_class), .exc_in(exc_in), .trap_req(trap_req),
        .pred_sel(pred_sel), .pred_out(pred_out)
    );

    // vector: {is_move, sign, class[1:0], exc[7:0], expected flags N Z I NaN}
    typedef logic [15:0] vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, 2'd0, 8'h00, 4'b0000},
        {1'b0, 1'b1, 2'd0, 8'h01, 4'b1000},
        {1'b0, 1'b0, 2'd1, 8'h00, 4'b0100},
        {1'b0, 1'b1, 2'd1, 8'h08, 4'b1100},
        {1'b0, 1'b0, 2'd2, 8'h10, 4'b0010},
        {1'b1, 1'b1, 2'd3, 8'h04, 4'b0010},
        {1'b0, 1'b1, 2'd3, 8'h80, 4'b1001},
        {1'b0, 1'b1, 2'd2, 8'h20, 4'b1010}
    };
    localparam logic [7:0] ENABLES = 8'h24;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic ref_pred(input logic [3:0] f, input int sel);
        logic n, z, u;
        n = f[3]; z = f[2]; u = f[0];
        case (sel)
            0: return z;
            1: return !u && !z && !n;
            2: return n && !z && !u;
            default: return u;
        endcase
    endfunction

    task automatic read_word(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_preds(input logic [3:0] f, input string tag);
        for (int s = 0; s < 4; s++) begin
            pred_sel = 2'(s);
            #1;
            check(tag, {31'b0, pred_out}, {31'b0, ref_pred(f, s)});
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  acc;
        logic [7:0]  ex;
        logic        trap_exp;

        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_word(1'b0, v); check("R1 ctrl reset", v, 32'h0);
        read_word(1'b1, v); check("R1 stat reset", v, 32'h0);

        // R2 control masking
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_wr = 1'b0;
        read_word(1'b0, v); check("R2 ctrl mask", v, 32'h0000_FFF0);

        // R3 status direct write
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_wr = 1'b0;
        read_word(1'b1, v); check("R3 stat write", v, 32'h0FFF_FFFF);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0912_3456;
        @(negedge clk); reg_wr = 1'b0;
        read_word(1'b1, v); check("R3 stat pattern", v, 32'h0912_3456);
        check_preds(4'b1001, "R11 preds on written flags");

        // R7 software write clears accrued; set enables
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0;
        @(negedge clk);
        reg_sel = 1'b0; reg_wdata = {16'h0, ENABLES, 8'h50};
        @(negedge clk); reg_wr = 1'b0;
        read_word(1'b1, v); check("R7 accrued cleared by write", v, 32'h0);

        // Table walk: R4 R5 R6 R7 R8 R11
        acc = 8'h00;
        for (int i = 0; i < NV; i++) begin
            ex = VECS[i][11:4];
            upd_valid = 1'b1; upd_is_move = VECS[i][15]; res_sign = VECS[i][14];
            res_class = VECS[i][13:12]; exc_in = ex;
            acc = acc | ex;
            trap_exp = |(ex & ENABLES);
            @(negedge clk);
            upd_valid = 1'b0;
            read_word(1'b1, v);
            check($sformatf("R4 R5 flags vec %0d", i), {28'h0, v[27:24]}, {28'h0, VECS[i][3:0]});
            check($sformatf("R6 exc byte vec %0d", i), {24'h0, v[15:8]}, {24'h0, ex});
            check($sformatf("R7 accrued vec %0d", i), {24'h0, v[7:0]}, {24'h0, acc});
            check($sformatf("R8 trap vec %0d", i), {31'h0, trap_req}, {31'h0, trap_exp});
            check_preds(VECS[i][3:0], $sformatf("R11 vec %0d", i));
        end

        // R8 trap lasts one cycle
        upd_valid = 1'b1; upd_is_move = 1'b0; exc_in = 8'h20; res_class = 2'd0;
        @(negedge clk); upd_valid = 1'b0;
        check("R8 trap high", {31'h0, trap_req}, 32'h1);
        @(negedge clk);
        check("R8 trap one cycle", {31'h0, trap_req}, 32'h0);

        // R9 write beats update
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_1234;
        upd_valid = 1'b1; res_class = 2'd2; exc_in = 8'h04;
        @(negedge clk); reg_wr = 1'b0; upd_valid = 1'b0;
        read_word(1'b1, v); check("R9 write wins", v, 32'h0000_1234);
        check("R9 no trap", {31'h0, trap_req}, 32'h0);

        // R10 state clear
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0ABC_DEF0;
        @(negedge clk); reg_wr = 1'b0;
        clr_state = 1'b1; upd_valid = 1'b1; exc_in = 8'h24;
        @(negedge clk); clr_state = 1'b0; upd_valid = 1'b0;
        read_word(1'b1, v); check("R10 stat cleared", v, 32'h0);
        read_word(1'b0, v); check("R10 ctrl kept", v, {16'h0, ENABLES, 8'h50});
        check("R10 no trap", {31'h0, trap_req}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule